// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block predicts which loads must be held back until an earlier, still in-flight store has issued. It keeps two tables. The identifier table maps an instruction address to a store set number. It is read in the decode stage, and its result comes back one cycle after the lookup. The tracking table maps a store set number to the tag of the most recently dispatched store of that set. It is read in the dispatch stage. For every dispatched load that carries a valid set number, the block returns a wait flag and the tag of the store the load must wait for.

Training comes from memory-order violations that the load queue reports. Each report names the address of the offending load and the fetch address of the offending store. Training either puts both in a new set or merges their existing sets. The identifier table is wiped on a fixed period, so that stale pairings do not build up. Entries in the tracking table are released in three ways: when the named store issues, when a pipeline redirect squashes younger stores, or when a newer store of the same set overwrites them. Stores of one set may issue in any order among themselves. Only the dependency of a load on the last store of its set is enforced.

Top module: `store_set_pred`

## Requirements
- R1: After reset every identifier entry is invalid and every tracking entry is empty. A decode lookup returns `dec_ssid_vld`=0 and no load waits.
- R2: A decode lookup on lane i uses address bits [IDX_W+1:2] as the table index, where IDX_W is log2 of the table depth. The result is registered and appears one clock after the request. `dec_ssid_vld[i]` is 1 only if `dec_valid[i]` was 1 and the entry was valid.
- R3: A violation writes the same set number into the load's entry and the store's entry, by these rules. If neither entry is valid, both get a freshly allocated number; allocation starts at 0 after reset and increases by one for each new set. If exactly one entry is valid, the other takes its number. If both are valid, both take the smaller of the two numbers. No other entry changes.
- R4: If a decode lookup and a violation write hit the same identifier entry in the same cycle, the lookup returns the newly written number as valid.
- R5: A store dispatched with a valid set number is recorded in the tracking table two clock edges after dispatch. A load of that set dispatched one cycle after the store does not see it. A load dispatched two cycles after the store does see it.
- R6: A dispatched load with a valid set number waits if the tracking entry for that set is occupied, and `wait_tag` is then the recorded tag. A load without a valid set number never waits.
- R7: A load waits for an older store (lower lane) in the same dispatch bundle that has the same valid set number. `wait_tag` is then the tag of the nearest such store, and this takes precedence over the tracking table. A store in a higher lane does not make the load wait.
- R8: A store-issue report empties the tracking entry of its set only if the recorded tag equals the issued tag. The report takes effect two edges after it is presented.
- R9: A redirect empties every tracking entry whose tag is strictly younger than the redirect tag. Tags are TAG_W bits: the MSB is a wrap flag and the low bits are a position. Tag a is younger than tag b when the flags are equal and a's position is larger, or when the flags differ and a's position is smaller.
- R10: All identifier entries become invalid once every FLUSH_PERIOD cycles.
- R11: With ENABLE=0, `load_wait` is never asserted.
- R12: A store lane never asserts `load_wait`, so stores of one set are not ordered among themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | LANES | Decode lookup request per lane |
| dec_pc | input | LANES*PC_W | Instruction address per decode lane |
| dec_ssid_vld | output | LANES | Registered: lane has a valid set number |
| dec_ssid | output | LANES*SSID_W | Registered set number per lane |
| disp_valid | input | LANES | Dispatch slot occupied |
| disp_is_load | input | LANES | Slot holds a load |
| disp_is_store | input | LANES | Slot holds a store |
| disp_ssid_vld | input | LANES | Slot carries a valid set number |
| disp_ssid | input | LANES*SSID_W | Set number per slot |
| disp_tag | input | LANES*TAG_W | Store tag per slot |
| load_wait | output | LANES | Load must wait |
| wait_tag | output | LANES*TAG_W | Tag of the store to wait for |
| iss_valid | input | 1 | A store issued |
| iss_ssid | input | SSID_W | Set number of the issued store |
| iss_tag | input | TAG_W | Tag of the issued store |
| redir_valid | input | 1 | Pipeline redirect |
| redir_tag | input | TAG_W | Redirect point tag |
| viol_valid | input | 1 | Memory-order violation report |
| viol_ld_pc | input | PC_W | Address of the offending load |
| viol_st_pc | input | PC_W | Fetch address of the offending store |

## Verification
If the identifier table holds a wrong valid bit or set number, the decode outputs show it one clock after a lookup of that address. A wrong merge therefore shows up on the first decode of either trained address. If the tracking table holds a stale entry or misses one, a load of that set dispatched two cycles after the update gets a wrong `load_wait` or `wait_tag`. The bench applies every table change, then dispatches a probing load, so that the entry it touched is visible in the same low clock phase.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   typedef enum logic [1:0] {
      MRG_NEW     = 2'd0,
      MRG_TAKE_LD = 2'd1,
      MRG_TAKE_ST = 2'd2,
      MRG_MIN     = 2'd3
   } ssp_merge_e;

   function automatic ssp_merge_e merge_kind(input logic ld_v, input logic st_v);
      case ({ld_v, st_v})
         2'b00:   return MRG_NEW;
         2'b10:   return MRG_TAKE_LD;
         2'b01:   return MRG_TAKE_ST;
         default: return MRG_MIN;
      endcase
   endfunction

endpackage

// File: rtl/ssp_ssit.sv
module ssp_ssit
   import ssp_pkg::*;
#(
   parameter int PC_W         = 32,
   parameter int DEPTH        = 1024,
   parameter int SSID_W       = 5,
   parameter int LANES        = 2,
   parameter int FLUSH_PERIOD = 131072
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        dec_valid,
   input  logic [LANES*PC_W-1:0]   dec_pc,
   input  logic                    viol_valid,
   input  logic [PC_W-1:0]         viol_ld_pc,
   input  logic [PC_W-1:0]         viol_st_pc,
   output logic [LANES-1:0]        dec_ssid_vld,
   output logic [LANES*SSID_W-1:0] dec_ssid
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(FLUSH_PERIOD);

   if (DEPTH != (1 << IDX_W)) begin : g_bad_depth
      $error("ssp_ssit: DEPTH must be a power of two");
   end
   if (PC_W < IDX_W + 2) begin : g_bad_pc
      $error("ssp_ssit: PC_W too narrow for the index");
   end
   if (FLUSH_PERIOD < 2) begin : g_bad_period
      $error("ssp_ssit: FLUSH_PERIOD must be at least 2");
   end

   logic [DEPTH-1:0]  vld_q;
   logic [SSID_W-1:0] id_q [DEPTH];
   logic [SSID_W-1:0] alloc_q;
   logic [CNT_W-1:0]  cnt_q;

   logic [IDX_W-1:0]  ld_idx, st_idx;
   logic [SSID_W-1:0] ld_id, st_id, wr_id;
   ssp_merge_e        kind;
   logic              flush_now, wr_en;

   assign ld_idx    = viol_ld_pc[IDX_W+1:2];
   assign st_idx    = viol_st_pc[IDX_W+1:2];
   assign ld_id     = id_q[ld_idx];
   assign st_id     = id_q[st_idx];
   assign kind      = merge_kind(vld_q[ld_idx], vld_q[st_idx]);
   assign flush_now = (cnt_q == CNT_W'(FLUSH_PERIOD - 1));
   assign wr_en     = viol_valid && !flush_now;

   always_comb begin
      case (kind)
         MRG_NEW:     wr_id = alloc_q;
         MRG_TAKE_LD: wr_id = ld_id;
         MRG_TAKE_ST: wr_id = st_id;
         default:     wr_id = (ld_id < st_id) ? ld_id : st_id;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         alloc_q <= '0;
      end else begin
         cnt_q <= flush_now ? '0 : cnt_q + 1'b1;
         if (wr_en && kind == MRG_NEW) alloc_q <= alloc_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (flush_now) begin
         vld_q <= '0;
      end else if (viol_valid) begin
         vld_q[ld_idx] <= 1'b1;
         vld_q[st_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         id_q[ld_idx] <= wr_id;
         id_q[st_idx] <= wr_id;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_rd
      logic [IDX_W-1:0]  idx;
      logic              hit, rd_v;
      logic [SSID_W-1:0] rd_id;
      assign idx   = dec_pc[i*PC_W+2 +: IDX_W];
      assign hit   = wr_en && (idx == ld_idx || idx == st_idx);
      assign rd_v  = !flush_now && (hit || vld_q[idx]);
      assign rd_id = hit ? wr_id : id_q[idx];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dec_ssid_vld[i] <= 1'b0;
         end else begin
            dec_ssid_vld[i] <= dec_valid[i] && rd_v;
         end
         dec_ssid[i*SSID_W +: SSID_W] <= rd_id;
      end
   end

endmodule

// File: rtl/ssp_lfst.sv
module ssp_lfst #(
   parameter int SSID_W = 5,
   parameter int TAG_W  = 7,
   parameter int LANES  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LANES-1:0]            st_wr_valid,
   input  logic [LANES*SSID_W-1:0]     st_wr_ssid,
   input  logic [LANES*TAG_W-1:0]      st_wr_tag,
   input  logic                        iss_valid,
   input  logic [SSID_W-1:0]           iss_ssid,
   input  logic [TAG_W-1:0]            iss_tag,
   input  logic                        redir_valid,
   input  logic [TAG_W-1:0]            redir_tag,
   output logic [(1<<SSID_W)-1:0]      ent_vld,
   output logic [(1<<SSID_W)*TAG_W-1:0] ent_tag
);
   localparam int DEPTH = 1 << SSID_W;
   localparam int POS_W = TAG_W - 1;

   if (TAG_W < 2) begin : g_bad_tag
      $error("ssp_lfst: TAG_W needs a wrap flag and at least one position bit");
   end

   function automatic logic is_younger(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
      if (a[POS_W] == b[POS_W]) return a[POS_W-1:0] > b[POS_W-1:0];
      else                      return a[POS_W-1:0] < b[POS_W-1:0];
   endfunction

   // one-cycle delay stage on every update input
   logic [LANES-1:0]        wr_v_d;
   logic [LANES*SSID_W-1:0] wr_ssid_d;
   logic [LANES*TAG_W-1:0]  wr_tag_d;
   logic                    iss_v_d, redir_v_d;
   logic [SSID_W-1:0]       iss_ssid_d;
   logic [TAG_W-1:0]        iss_tag_d, redir_tag_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_v_d    <= '0;
         iss_v_d   <= 1'b0;
         redir_v_d <= 1'b0;
      end else begin
         wr_v_d    <= st_wr_valid;
         iss_v_d   <= iss_valid;
         redir_v_d <= redir_valid;
      end
      wr_ssid_d   <= st_wr_ssid;
      wr_tag_d    <= st_wr_tag;
      iss_ssid_d  <= iss_ssid;
      iss_tag_d   <= iss_tag;
      redir_tag_d <= redir_tag;
   end

   logic [DEPTH-1:0] vld_q;
   logic [TAG_W-1:0] tag_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic             nv;
      logic [TAG_W-1:0] nt;
      always_comb begin
         nv = vld_q[e];
         nt = tag_q[e];
         for (int l = 0; l < LANES; l++) begin
            if (wr_v_d[l] && wr_ssid_d[l*SSID_W +: SSID_W] == SSID_W'(e)) begin
               nv = 1'b1;
               nt = wr_tag_d[l*TAG_W +: TAG_W];
            end
         end
         if (iss_v_d && iss_ssid_d == SSID_W'(e) && nt == iss_tag_d) nv = 1'b0;
         if (redir_v_d && is_younger(nt, redir_tag_d)) nv = 1'b0;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) vld_q[e] <= 1'b0;
         else        vld_q[e] <= nv;
         tag_q[e] <= nt;
      end
      assign ent_tag[e*TAG_W +: TAG_W] = tag_q[e];
   end

   assign ent_vld = vld_q;

endmodule

// File: rtl/ssp_disp_check.sv
module ssp_disp_check #(
   parameter int SSID_W = 5,
   parameter int TAG_W  = 7,
   parameter int LANES  = 2,
   parameter bit ENABLE = 1'b1
) (
   input  logic [LANES-1:0]             disp_valid,
   input  logic [LANES-1:0]             disp_is_load,
   input  logic [LANES-1:0]             disp_is_store,
   input  logic [LANES-1:0]             disp_ssid_vld,
   input  logic [LANES*SSID_W-1:0]      disp_ssid,
   input  logic [LANES*TAG_W-1:0]       disp_tag,
   input  logic [(1<<SSID_W)-1:0]       ent_vld,
   input  logic [(1<<SSID_W)*TAG_W-1:0] ent_tag,
   output logic [LANES-1:0]             load_wait,
   output logic [LANES*TAG_W-1:0]       wait_tag
);
   localparam int DEPTH = 1 << SSID_W;

   logic [TAG_W-1:0]  et  [DEPTH];
   logic [SSID_W-1:0] sid [LANES];
   logic [TAG_W-1:0]  tg  [LANES];
   logic [LANES-1:0]  st_ok;

   for (genvar e = 0; e < DEPTH; e++) begin : g_unpack_ent
      assign et[e] = ent_tag[e*TAG_W +: TAG_W];
   end
   for (genvar l = 0; l < LANES; l++) begin : g_unpack_lane
      assign sid[l]   = disp_ssid[l*SSID_W +: SSID_W];
      assign tg[l]    = disp_tag[l*TAG_W +: TAG_W];
      assign st_ok[l] = disp_valid[l] && disp_is_store[l] && disp_ssid_vld[l];
   end

   if (ENABLE) begin : g_on
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic             w;
         logic [TAG_W-1:0] t;
         always_comb begin
            w = 1'b0;
            t = '0;
            if (disp_valid[i] && disp_is_load[i] && disp_ssid_vld[i]) begin
               if (ent_vld[sid[i]]) begin
                  w = 1'b1;
                  t = et[sid[i]];
               end
               for (int j = 0; j < i; j++) begin
                  if (st_ok[j] && sid[j] == sid[i]) begin
                     w = 1'b1;
                     t = tg[j];
                  end
               end
            end
         end
         assign load_wait[i]             = w;
         assign wait_tag[i*TAG_W +: TAG_W] = t;
      end
   end else begin : g_off
      assign load_wait = '0;
      assign wait_tag  = '0;
   end

endmodule

// File: rtl/store_set_pred.sv
module store_set_pred #(
   parameter int PC_W         = 32,
   parameter int SSIT_DEPTH   = 1024,
   parameter int SSID_W       = 5,
   parameter int TAG_W        = 7,
   parameter int LANES        = 2,
   parameter int FLUSH_PERIOD = 131072,
   parameter bit ENABLE       = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        dec_valid,
   input  logic [LANES*PC_W-1:0]   dec_pc,
   output logic [LANES-1:0]        dec_ssid_vld,
   output logic [LANES*SSID_W-1:0] dec_ssid,
   input  logic [LANES-1:0]        disp_valid,
   input  logic [LANES-1:0]        disp_is_load,
   input  logic [LANES-1:0]        disp_is_store,
   input  logic [LANES-1:0]        disp_ssid_vld,
   input  logic [LANES*SSID_W-1:0] disp_ssid,
   input  logic [LANES*TAG_W-1:0]  disp_tag,
   output logic [LANES-1:0]        load_wait,
   output logic [LANES*TAG_W-1:0]  wait_tag,
   input  logic                    iss_valid,
   input  logic [SSID_W-1:0]       iss_ssid,
   input  logic [TAG_W-1:0]        iss_tag,
   input  logic                    redir_valid,
   input  logic [TAG_W-1:0]        redir_tag,
   input  logic                    viol_valid,
   input  logic [PC_W-1:0]         viol_ld_pc,
   input  logic [PC_W-1:0]         viol_st_pc
);
   localparam int LFST_DEPTH = 1 << SSID_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("store_set_pred: LANES must be at least 1");
   end

   logic [LFST_DEPTH-1:0]       ent_vld;
   logic [LFST_DEPTH*TAG_W-1:0] ent_tag;
   logic [LANES-1:0]            st_wr_valid;

   assign st_wr_valid = disp_valid & disp_is_store & disp_ssid_vld;

   ssp_ssit #(
      .PC_W(PC_W), .DEPTH(SSIT_DEPTH), .SSID_W(SSID_W),
      .LANES(LANES), .FLUSH_PERIOD(FLUSH_PERIOD)
   ) u_ssit (
      .clk(clk), .rst_n(rst_n),
      .dec_valid(dec_valid), .dec_pc(dec_pc),
      .viol_valid(viol_valid), .viol_ld_pc(viol_ld_pc), .viol_st_pc(viol_st_pc),
      .dec_ssid_vld(dec_ssid_vld), .dec_ssid(dec_ssid)
   );

   ssp_lfst #(.SSID_W(SSID_W), .TAG_W(TAG_W), .LANES(LANES)) u_lfst (
      .clk(clk), .rst_n(rst_n),
      .st_wr_valid(st_wr_valid), .st_wr_ssid(disp_ssid), .st_wr_tag(disp_tag),
      .iss_valid(iss_valid), .iss_ssid(iss_ssid), .iss_tag(iss_tag),
      .redir_valid(redir_valid), .redir_tag(redir_tag),
      .ent_vld(ent_vld), .ent_tag(ent_tag)
   );

   ssp_disp_check #(.SSID_W(SSID_W), .TAG_W(TAG_W), .LANES(LANES), .ENABLE(ENABLE)) u_chk_disp (
      .disp_valid(disp_valid), .disp_is_load(disp_is_load), .disp_is_store(disp_is_store),
      .disp_ssid_vld(disp_ssid_vld), .disp_ssid(disp_ssid), .disp_tag(disp_tag),
      .ent_vld(ent_vld), .ent_tag(ent_tag),
      .load_wait(load_wait), .wait_tag(wait_tag)
   );

endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
   parameter int SSID_W = 5,
   parameter int TAG_W  = 7,
   parameter int LANES  = 2,
   parameter bit ENABLE = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [LANES-1:0]        dec_valid,
   input logic [LANES-1:0]        dec_ssid_vld,
   input logic [LANES-1:0]        disp_valid,
   input logic [LANES-1:0]        disp_is_load,
   input logic [LANES-1:0]        disp_is_store,
   input logic [LANES-1:0]        disp_ssid_vld,
   input logic [LANES*SSID_W-1:0] disp_ssid,
   input logic [LANES*TAG_W-1:0]  disp_tag,
   input logic [LANES-1:0]        load_wait,
   input logic [LANES*TAG_W-1:0]  wait_tag
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      p_dec_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
         dec_ssid_vld[i] |-> $past(dec_valid[i]));

      p_wait_only_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
         load_wait[i] |-> (disp_valid[i] && disp_is_load[i] && disp_ssid_vld[i]));

      p_store_no_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (disp_is_store[i] && !disp_is_load[i]) |-> !load_wait[i]);

      if (ENABLE && i > 0) begin : g_bundle
         p_bundle_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_valid[i] && disp_is_load[i] && disp_ssid_vld[i] &&
             disp_valid[i-1] && disp_is_store[i-1] && disp_ssid_vld[i-1] &&
             disp_ssid[i*SSID_W +: SSID_W] == disp_ssid[(i-1)*SSID_W +: SSID_W])
            |-> (load_wait[i] && wait_tag[i*TAG_W +: TAG_W] == disp_tag[(i-1)*TAG_W +: TAG_W]));
      end
   end
endmodule

bind store_set_pred ssp_chk #(
   .SSID_W(SSID_W), .TAG_W(TAG_W), .LANES(LANES), .ENABLE(ENABLE)
) u_ssp_chk (.*);

// File: tb/sim_store_set_pred.sv
module sim_store_set_pred;
   localparam int PC_W = 32, SSID_W = 5, TAG_W = 7, LANES = 2, FP = 4096;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [LANES-1:0]        dec_valid, disp_valid, disp_is_load, disp_is_store, disp_ssid_vld;
   logic [LANES*PC_W-1:0]   dec_pc;
   logic [LANES*SSID_W-1:0] disp_ssid;
   logic [LANES*TAG_W-1:0]  disp_tag;
   logic                    iss_valid, redir_valid, viol_valid;
   logic [SSID_W-1:0]       iss_ssid;
   logic [TAG_W-1:0]        iss_tag, redir_tag;
   logic [PC_W-1:0]         viol_ld_pc, viol_st_pc;

   logic [LANES-1:0]        dec_ssid_vld, load_wait, dec_ssid_vld1, load_wait1;
   logic [LANES*SSID_W-1:0] dec_ssid, dec_ssid1;
   logic [LANES*TAG_W-1:0]  wait_tag, wait_tag1;

   store_set_pred #(.PC_W(PC_W), .SSID_W(SSID_W), .TAG_W(TAG_W), .LANES(LANES),
                    .FLUSH_PERIOD(FP), .ENABLE(1'b1)) u0 (
      .clk, .rst_n, .dec_valid, .dec_pc, .dec_ssid_vld, .dec_ssid,
      .disp_valid, .disp_is_load, .disp_is_store, .disp_ssid_vld, .disp_ssid, .disp_tag,
      .load_wait, .wait_tag, .iss_valid, .iss_ssid, .iss_tag, .redir_valid, .redir_tag,
      .viol_valid, .viol_ld_pc, .viol_st_pc);

   store_set_pred #(.PC_W(PC_W), .SSID_W(SSID_W), .TAG_W(TAG_W), .LANES(LANES),
                    .FLUSH_PERIOD(FP), .ENABLE(1'b0)) u1 (
      .clk, .rst_n, .dec_valid, .dec_pc, .dec_ssid_vld(dec_ssid_vld1), .dec_ssid(dec_ssid1),
      .disp_valid, .disp_is_load, .disp_is_store, .disp_ssid_vld, .disp_ssid, .disp_tag,
      .load_wait(load_wait1), .wait_tag(wait_tag1), .iss_valid, .iss_ssid, .iss_tag,
      .redir_valid, .redir_tag, .viol_valid, .viol_ld_pc, .viol_st_pc);

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   // {load pc, store pc, expected set number}
   localparam logic [68:0] VEC [6] = '{
      {32'h100, 32'h200, 5'd0},
      {32'h300, 32'h200, 5'd0},
      {32'h400, 32'h500, 5'd1},
      {32'h400, 32'h600, 5'd1},
      {32'h400, 32'h100, 5'd0},
      {32'h700, 32'h800, 5'd2}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      dec_valid = '0; dec_pc = '0;
      disp_valid = '0; disp_is_load = '0; disp_is_store = '0; disp_ssid_vld = '0;
      disp_ssid = '0; disp_tag = '0;
      iss_valid = 1'b0; iss_ssid = '0; iss_tag = '0;
      redir_valid = 1'b0; redir_tag = '0;
      viol_valid = 1'b0; viol_ld_pc = '0; viol_st_pc = '0;
   endtask

   task automatic lane(input int l, input logic ld, input logic st, input logic sv,
                       input logic [SSID_W-1:0] s, input logic [TAG_W-1:0] t);
      disp_valid[l] = 1'b1; disp_is_load[l] = ld; disp_is_store[l] = st;
      disp_ssid_vld[l] = sv;
      disp_ssid[l*SSID_W +: SSID_W] = s;
      disp_tag[l*TAG_W +: TAG_W] = t;
   endtask

   task automatic nxt(); @(negedge clk); idle(); endtask

   // decode two addresses, results checked one clock later
   task automatic lookup(input string req, input logic [31:0] pa, input logic [31:0] pb,
                         input logic va, input logic [4:0] ia,
                         input logic vb, input logic [4:0] ib);
      @(negedge clk); idle();
      dec_valid = 2'b11; dec_pc = {pb, pa};
      @(negedge clk); idle();
      chk({req, " vld lane0"}, 32'(dec_ssid_vld[0]), 32'(va));
      chk({req, " vld lane1"}, 32'(dec_ssid_vld[1]), 32'(vb));
      if (va) chk({req, " id lane0"}, 32'(dec_ssid[4:0]), 32'(ia));
      if (vb) chk({req, " id lane1"}, 32'(dec_ssid[9:5]), 32'(ib));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      lookup("R1 decode after reset", 32'h100, 32'h200, 1'b0, 5'd0, 1'b0, 5'd0);
      lane(0, 1'b1, 1'b0, 1'b1, 5'd0, 7'd0); #1;
      chk("R1 no wait after reset", 32'(load_wait[0]), 32'd0);

      // R2 R3: training vectors
      for (int k = 0; k < 6; k++) begin
         nxt();
         viol_valid = 1'b1; viol_ld_pc = VEC[k][68:37]; viol_st_pc = VEC[k][36:5];
         lookup("R3 R2 merge vector", VEC[k][68:37], VEC[k][36:5],
                1'b1, VEC[k][4:0], 1'b1, VEC[k][4:0]);
      end
      lookup("R3 untouched entry", 32'h500, 32'h900, 1'b1, 5'd1, 1'b0, 5'd0);

      // R4: same-cycle write and lookup
      nxt();
      viol_valid = 1'b1; viol_ld_pc = 32'h900; viol_st_pc = 32'hA00;
      dec_valid = 2'b11; dec_pc = {32'hA00, 32'h900};
      nxt();
      chk("R4 bypass vld", 32'(dec_ssid_vld), 32'd3);
      chk("R4 bypass id", 32'(dec_ssid), {22'd0, 5'd3, 5'd3});

      // R5 R6: store recorded after two edges
      nxt(); lane(0, 1'b0, 1'b1, 1'b1, 5'd3, 7'd10);
      nxt(); lane(0, 1'b1, 1'b0, 1'b1, 5'd3, 7'd0); #1;
      chk("R5 not yet visible", 32'(load_wait[0]), 32'd0);
      nxt(); lane(0, 1'b1, 1'b0, 1'b1, 5'd3, 7'd0);
             lane(1, 1'b1, 1'b0, 1'b0, 5'd3, 7'd0); #1;
      chk("R5 R6 visible wait", 32'(load_wait[0]), 32'd1);
      chk("R6 wait tag", 32'(wait_tag[6:0]), 32'd10);
      chk("R6 no set no wait", 32'(load_wait[1]), 32'd0);
      chk("R11 disabled no wait", 32'(load_wait1), 32'd0);

      // R8: matching issue clears
      nxt(); iss_valid = 1'b1; iss_ssid = 5'd3; iss_tag = 7'd10;
      nxt();
      nxt(); lane(0, 1'b1, 1'b0, 1'b1, 5'd3, 7'd0); #1;
      chk("R8 match clears", 32'(load_wait[0]), 32'd0);

      // R8: mismatching issue keeps entry
      nxt(); lane(0, 1'b0, 1'b1, 1'b1, 5'd5, 7'd30);
      nxt();
      nxt(); iss_valid = 1'b1; iss_ssid = 5'd5; iss_tag = 7'd31;
      nxt();
      nxt(); lane(0, 1'b1, 1'b0, 1'b1, 5'd5, 7'd0); #1;
      chk("R8 mismatch keeps", 32'(load_wait[0]), 32'd1);
      chk("R8 mismatch tag", 32'(wait_tag[6:0]), 32'd30);

      // R7: store in a higher lane does not count, older lane does
      nxt(); lane(0, 1'b1, 1'b0, 1'b1, 5'd4, 7'd0);
             lane(1, 1'b0, 1'b1, 1'b1, 5'd4, 7'd20); #1;
      chk("R7 younger store ignored", 32'(load_wait[0]), 32'd0);
      nxt();
      nxt(); lane(0, 1'b0, 1'b1, 1'b1, 5'd4, 7'd21);
             lane(1, 1'b1, 1'b0, 1'b1, 5'd4, 7'd0); #1;
      chk("R7 bundle wait", 32'(load_wait[1]), 32'd1);
      chk("R7 bundle tag over table", 32'(wait_tag[13:7]), 32'd21);

      // R9: redirect at flag0/pos20
      nxt(); lane(0, 1'b0, 1'b1, 1'b1, 5'd6, 7'd12);
             lane(1, 1'b0, 1'b1, 1'b1, 5'd7, 7'h45);
      nxt(); lane(0, 1'b0, 1'b1, 1'b1, 5'd8, 7'h59);
      nxt();
      nxt(); redir_valid = 1'b1; redir_tag = 7'd20;
      nxt();
      nxt(); lane(0, 1'b1, 1'b0, 1'b1, 5'd5, 7'd0);
             lane(1, 1'b1, 1'b0, 1'b1, 5'd6, 7'd0); #1;
      chk("R9 younger cleared", 32'(load_wait[0]), 32'd0);
      chk("R9 older kept", 32'(load_wait[1]), 32'd1);
      chk("R9 older tag", 32'(wait_tag[13:7]), 32'd12);
      nxt(); lane(0, 1'b1, 1'b0, 1'b1, 5'd7, 7'd0);
             lane(1, 1'b1, 1'b0, 1'b1, 5'd8, 7'd0); #1;
      chk("R9 wrapped younger cleared", 32'(load_wait[0]), 32'd0);
      chk("R9 wrapped older kept", 32'(load_wait[1]), 32'd1);
      chk("R9 wrapped older tag", 32'(wait_tag[13:7]), 32'h59);

      // R12: a store lane never waits, even with an occupied entry
      nxt(); lane(0, 1'b0, 1'b1, 1'b1, 5'd6, 7'd13); #1;
      chk("R12 store no wait", 32'(load_wait[0]), 32'd0);

      // R10: periodic flush
      nxt();
      lookup("R10 valid before flush", 32'h100, 32'h400, 1'b1, 5'd0, 1'b1, 5'd0);
      repeat (FP + 10) @(negedge clk);
      lookup("R10 flushed", 32'h100, 32'h400, 1'b0, 5'd0, 1'b0, 5'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule